// File: doc/BRIEF.md
# Hibernate Entry and Wakeup Controller

This block sequences a small system between three power states: run, hibernate and reset. Firmware asks for hibernate by writing a request bit in a control register. The controller accepts the request only when two conditions hold. First, a hibernate lock bit must be clear; once firmware sets that bit, only a reset can clear it. Second, the supply must have been reported good for an unbroken qualification window.

While hibernated, the controller turns off the brownout monitor and ignores brownout strobes. It holds a debug-disconnect indication and waits for a wakeup. A wakeup comes either from an enabled bit of the wake-source vector or from the real-time-clock alarm. Three sources force the reset state, and they override everything else: the external reset pin, power-on reset, and brownout reset outside hibernate.

A wakeup returns to run, clears the request bit and keeps every other register bit. A request that is refused is dropped and sets a sticky rejection flag, which firmware clears by writing 1 to it.

Top module: `hib_ctrl_top`

## Requirements
- R1: When `ext_rst_n` is low or `por_req` is high, the next clock edge puts the block in reset (`in_reset`=1, `hib_active`=0). It clears every register bit and the qualification counter. This holds in every state.
- R2: In run, a write to the control register (`reg_sel`=0) with bit 31 set is accepted when the lock is clear and the window is complete. The edge of that write enters hibernate, and bit 31 then reads 1.
- R3: Control bit 30 (hibernate lock) is set by writing 1. Writing 0 does not clear it; only the reset state returns it to 0.
- R4: A request written while the lock is set, or with bit 30 set in the same write, is refused: the block stays in run and control bit 0 (rejected flag) becomes 1.
- R5: The window is complete only after `supply_ok` has been high for `STAB_CYC` consecutive edges since reset. A low `supply_ok` restarts the count. A request made before completion is refused as in R4.
- R6: `bod_mon_en` is 0 exactly while hibernated. `bod_req` then has no effect. Outside hibernate, `bod_req` acts like R1.
- R7: The wake-enable register (`reg_sel`=1) bits [NWAKE-1:0] gate `wake_src` bit for bit. While hibernated, any enabled high source returns the block to run on the next edge. Bit 31 is cleared there, and the lock, the rejected flag and the wake enables keep their values. Disabled sources have no effect.
- R8: While hibernated, `rtc_alarm` always wakes the block, independent of the wake enables.
- R9: `dbg_disc` rises on the edge that enters hibernate and stays high until wakeup or reset.
- R10: Writing 1 to control bit 0 clears the rejected flag; writing 0 leaves it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| ext_rst_n | input | 1 | External reset pin, active low |
| por_req | input | 1 | Power-on reset request |
| bod_req | input | 1 | Brownout reset request |
| supply_ok | input | 1 | Supply reported stable |
| wake_src | input | NWAKE | Synchronised wakeup levels |
| rtc_alarm | input | 1 | Real-time-clock wakeup strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0: control register, 1: wake-enable register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| hib_active | output | 1 | Hibernate state active |
| dbg_disc | output | 1 | Debug disconnect |
| bod_mon_en | output | 1 | Brownout monitor enable |
| in_reset | output | 1 | Reset state active |

## Verification
The bench sets `STAB_CYC` to 20 and `NWAKE` to 4. At the default window length, reaching the end of the window would take tens of thousands of cycles. With these values the bench can reach the window's last-cycle refusal, restart it after a one-cycle supply drop, and still spend most of its time on hibernate sessions. With four wake sources the bench can try enabled, disabled, partly overlapping and empty masks, and it checks each against the wake outcome and the readback of the kept registers.

// File: rtl/hib_pkg.sv
package hib_pkg;
    localparam int DW      = 32;
    localparam int REQ_BIT = 31;
    localparam int DIS_BIT = 30;
    localparam int REJ_BIT = 0;

    typedef enum logic [1:0] {
        PS_RESET = 2'd0,
        PS_RUN   = 2'd1,
        PS_HIB   = 2'd2
    } pstate_e;

    typedef struct packed {
        logic req;
        logic lock;
        logic rej;
    } ctrl_t;

    function automatic logic [DW-1:0] pack_ctrl(input ctrl_t c);
        logic [DW-1:0] v;
        v = '0;
        v[REQ_BIT] = c.req;
        v[DIS_BIT] = c.lock;
        v[REJ_BIT] = c.rej;
        return v;
    endfunction
endpackage

// File: rtl/hib_stab.sv
module hib_stab #(
    parameter int STAB_CYC = 31250
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic supply_ok,
    output logic stab_done
);
    localparam int CW = $clog2(STAB_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(STAB_CYC);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr || !supply_ok)
            cnt_q <= '0;
        else if (cnt_q != LIMIT)
            cnt_q <= cnt_q + 1'b1;
    end

    assign stab_done = (cnt_q == LIMIT);

    // R5
    supply_restart_chk: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> !stab_done);
endmodule

// File: rtl/hib_fsm.sv
module hib_fsm
    import hib_pkg::*;
#(
    parameter int NWAKE = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_rst_n,
    input  logic             por_req,
    input  logic             bod_req,
    input  logic [NWAKE-1:0] wake_src,
    input  logic [NWAKE-1:0] wake_en,
    input  logic             rtc_alarm,
    input  logic             go_hib,
    output pstate_e          state,
    output logic             rst_cond,
    output logic             wake_evt
);
    pstate_e st_q;

    assign rst_cond = !ext_rst_n || por_req || (bod_req && st_q != PS_HIB);
    assign wake_evt = (st_q == PS_HIB) && ((|(wake_src & wake_en)) || rtc_alarm);

    always_ff @(posedge clk) begin
        if (rst || rst_cond)
            st_q <= PS_RESET;
        else begin
            unique case (st_q)
                PS_RESET: st_q <= PS_RUN;
                PS_RUN:   if (go_hib) st_q <= PS_HIB;
                PS_HIB:   if (wake_evt) st_q <= PS_RUN;
                default:  st_q <= PS_RESET;
            endcase
        end
    end

    assign state = st_q;

    // R8
    rtc_wake_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_HIB && rtc_alarm) |=> (st_q != PS_HIB));
    // R1
    pin_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (!ext_rst_n || por_req) |=> (st_q == PS_RESET));
endmodule

// File: rtl/hib_regs.sv
module hib_regs
    import hib_pkg::*;
#(
    parameter int NWAKE = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  pstate_e          state,
    input  logic             stab_done,
    input  logic             wake_evt,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic [NWAKE-1:0] wake_en,
    output logic             go_hib
);
    ctrl_t            ctrl_q;
    logic [NWAKE-1:0] wen_q;
    logic             ctrl_wr, ask, refuse;

    assign ctrl_wr = reg_wr && !reg_sel;
    assign ask     = ctrl_wr && reg_wdata[REQ_BIT] && (state == PS_RUN);
    assign go_hib  = ask && !ctrl_q.lock && !reg_wdata[DIS_BIT] && stab_done;
    assign refuse  = ask && !go_hib;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ctrl_q <= '0;
            wen_q  <= '0;
        end else begin
            if (go_hib)
                ctrl_q.req <= 1'b1;
            else if (wake_evt)
                ctrl_q.req <= 1'b0;
            if (ctrl_wr && reg_wdata[DIS_BIT])
                ctrl_q.lock <= 1'b1;
            if (refuse)
                ctrl_q.rej <= 1'b1;
            else if (ctrl_wr && reg_wdata[REJ_BIT])
                ctrl_q.rej <= 1'b0;
            if (reg_wr && reg_sel)
                wen_q <= reg_wdata[NWAKE-1:0];
        end
    end

    assign wake_en   = wen_q;
    assign reg_rdata = reg_sel ? {{(DW-NWAKE){1'b0}}, wen_q} : pack_ctrl(ctrl_q);

    // R3
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.lock && !clr) |=> ctrl_q.lock);
    // R4
    locked_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.lock && !clr) |=> !$rose(ctrl_q.req));
endmodule

// File: rtl/hib_ctrl_top.sv
module hib_ctrl_top
    import hib_pkg::*;
#(
    parameter int NWAKE    = 4,
    parameter int STAB_CYC = 31250
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_rst_n,
    input  logic             por_req,
    input  logic             bod_req,
    input  logic             supply_ok,
    input  logic [NWAKE-1:0] wake_src,
    input  logic             rtc_alarm,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             hib_active,
    output logic             dbg_disc,
    output logic             bod_mon_en,
    output logic             in_reset
);
    pstate_e          state;
    logic             rst_cond, wake_evt, go_hib, stab_done;
    logic [NWAKE-1:0] wake_en;

    hib_fsm #(.NWAKE(NWAKE)) fsm_i (
        .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .por_req(por_req),
        .bod_req(bod_req), .wake_src(wake_src), .wake_en(wake_en),
        .rtc_alarm(rtc_alarm), .go_hib(go_hib), .state(state),
        .rst_cond(rst_cond), .wake_evt(wake_evt)
    );

    hib_stab #(.STAB_CYC(STAB_CYC)) stab_i (
        .clk(clk), .rst(rst), .clr(rst_cond),
        .supply_ok(supply_ok), .stab_done(stab_done)
    );

    hib_regs #(.NWAKE(NWAKE)) regs_i (
        .clk(clk), .rst(rst), .clr(rst_cond), .state(state),
        .stab_done(stab_done), .wake_evt(wake_evt), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wake_en(wake_en), .go_hib(go_hib)
    );

    assign hib_active = (state == PS_HIB);
    assign dbg_disc   = (state == PS_HIB);
    assign bod_mon_en = (state != PS_HIB);
    assign in_reset   = (state == PS_RESET);

    // R5
    entry_window_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hib_active) |-> $past(stab_done));
    // R2
    req_tracks_state_chk: assert property (@(posedge clk) disable iff (rst)
        hib_active |-> reg_rdata[REQ_BIT] || reg_sel);
    // R6
    bod_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (hib_active && bod_req && ext_rst_n && !por_req) |=> !in_reset);
endmodule

// File: tb/hib_ctrl_top_tb_top.sv
module hib_ctrl_top_tb_top;
    localparam int NW = 4;
    localparam int SC = 20;

    logic clk = 1'b0, rst = 1'b1, ext_rst_n = 1'b1, por_req = 1'b0, bod_req = 1'b0;
    logic supply_ok = 1'b0, rtc_alarm = 1'b0, reg_wr = 1'b0, reg_sel = 1'b0;
    logic [NW-1:0] wake_src = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic hib_active, dbg_disc, bod_mon_en, in_reset;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    hib_ctrl_top #(.NWAKE(NW), .STAB_CYC(SC)) dut_i (
        .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .por_req(por_req),
        .bod_req(bod_req), .supply_ok(supply_ok), .wake_src(wake_src),
        .rtc_alarm(rtc_alarm), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hib_active(hib_active),
        .dbg_disc(dbg_disc), .bod_mon_en(bod_mon_en), .in_reset(in_reset)
    );

    // {wake enables, wake sources, wake expected}
    localparam logic [8:0] VEC [8] = '{
        {4'b0001, 4'b0001, 1'b1}, {4'b0001, 4'b0010, 1'b0},
        {4'b0110, 4'b0100, 1'b1}, {4'b0110, 4'b1001, 1'b0},
        {4'b1111, 4'b1000, 1'b1}, {4'b0000, 4'b1111, 1'b0},
        {4'b1010, 4'b0010, 1'b1}, {4'b0101, 4'b0000, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0; reg_sel = 1'b0;
        #1;
    endtask

    task automatic rd(input logic sel, output logic [31:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
        reg_sel = 1'b0;
        #1;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        tick(2);
        rst = 1'b0; supply_ok = 1'b1;
        tick();
        // R1 reset state: run, registers clear
        check("R1 run after reset", {hib_active, in_reset, bod_mon_en}, 3'b001);
        rd(0, d); check("R1 ctrl clear", d, 32'h0);

        // R5 early request refused, R4 rejected flag
        wr(0, 32'h8000_0000);
        check("R5 early request refused", hib_active, 0);
        rd(0, d); check("R4 rejected flag set", d, 32'h1);
        // R10 write 0 keeps, write 1 clears
        wr(0, 32'h0); rd(0, d); check("R10 write 0 keeps flag", d, 32'h1);
        wr(0, 32'h1); rd(0, d); check("R10 write 1 clears flag", d, 32'h0);

        // R5 restart after supply drop
        tick(SC);
        supply_ok = 1'b0; tick(); supply_ok = 1'b1;
        tick(SC - 1);
        wr(0, 32'h8000_0000);
        check("R5 restart after drop", hib_active, 0);
        wr(0, 32'h1);
        tick(2);

        // R7 table of wake masks
        for (int v = 0; v < 8; v++) begin
            wr(1, {28'h0, VEC[v][8:5]});
            wr(0, 32'h8000_0000);
            check("R2 entry accepted", hib_active, 1);
            check("R9 debug disconnect on entry", dbg_disc, 1);
            check("R6 monitor off in hibernate", bod_mon_en, 0);
            rd(0, d); check("R2 request bit reads 1", d[31], 1);
            wake_src = VEC[v][4:1];
            tick();
            wake_src = '0;
            check("R7 wake gating", hib_active, !VEC[v][0]);
            if (VEC[v][0]) begin
                rd(0, d); check("R7 request cleared on wake", d, 32'h0);
                rd(1, d); check("R7 enables kept", d, {28'h0, VEC[v][8:5]});
                check("R9 disconnect released", dbg_disc, 0);
            end else begin
                check("R9 disconnect held", dbg_disc, 1);
                rtc_alarm = 1'b1; tick(); rtc_alarm = 1'b0;
                check("R8 rtc wakes", hib_active, 0);
            end
        end

        // R6 brownout ignored in hibernate
        wr(1, 32'h0);
        wr(0, 32'h8000_0000);
        bod_req = 1'b1; tick(); bod_req = 1'b0;
        check("R6 brownout ignored in hibernate", {hib_active, in_reset}, 2'b10);
        rtc_alarm = 1'b1; tick(); rtc_alarm = 1'b0;
        // R6 brownout in run resets
        bod_req = 1'b1; tick(); bod_req = 1'b0;
        check("R6 brownout resets in run", in_reset, 1);
        tick(SC + 2);

        // R3 lock write-once, R4 locked request refused
        wr(1, 32'h5);
        wr(0, 32'h4000_0000);
        wr(0, 32'h0);
        rd(0, d); check("R3 lock survives write 0", d, 32'h4000_0000);
        wr(0, 32'h8000_0000);
        check("R4 locked request refused", hib_active, 0);
        rd(0, d); check("R4 rejected while locked", d, 32'h4000_0001);
        ext_rst_n = 1'b0; tick(); ext_rst_n = 1'b1;
        check("R1 pin reset", in_reset, 1);
        rd(0, d); check("R3 lock cleared by reset", d, 32'h0);
        rd(1, d); check("R1 enables cleared", d, 32'h0);
        tick(SC + 2);

        // R4 lock and request in same write
        wr(0, 32'hC000_0000);
        check("R4 same-write lock refuses", hib_active, 0);
        ext_rst_n = 1'b0; tick(); ext_rst_n = 1'b1;
        tick(SC + 2);

        // R1 power-on reset during hibernate
        wr(0, 32'h8000_0000);
        check("R2 entry before por", hib_active, 1);
        por_req = 1'b1; tick(); por_req = 1'b0;
        check("R1 por overrides hibernate", {hib_active, in_reset, dbg_disc}, 3'b010);
        tick();
        wr(0, 32'h8000_0000);
        check("R1 counter cleared by reset", hib_active, 0);

        finish_run();
    end
endmodule